// File: doc/BRIEF.md
# D-PHY Clock Lane HS Entry/Exit Sequencer

This block sequences the clock lane of a D-PHY transmitter between the low-power stop state and high-speed clocking. When high-speed clocking is requested, the lane leaves LP-11 and passes through a fixed series of line states. It then runs the clock for a programmed clock-pre interval before it tells the data lanes they may start. When the request is withdrawn, it keeps clocking for a programmed post interval, drives HS-0 for a trail interval, and returns to stop.

Every phase length is an 8-bit count of lane byte-clock cycles, taken from timing register fields. A count of zero gives one cycle. The post count already includes any data-lane trail allowance, and the block counts that value exactly once.

Each of the two analog enables, the high-speed driver enable and the low-power driver enable, can be taken from a register value instead of the state machine. A power-down input parks the lane, and with it the whole PHY, in an unpowered state. A synchronous soft reset returns the lane to stop. A 4-bit status word reports bias readiness, stop, ultra-low-power and high-speed activity.

Top module: `dclk_lane_seq`

## Requirements
- R1: After reset, and whenever the lane is in stop, the LP levels are 1/1 (dp, dn), tx_lp_en is 1, tx_hs_en is 0, hs_clk_run and data_ok are 0, and status bit 2 is 1.
- R2: A high hs_req sampled at a clock edge in stop starts entry at that edge. The lane shows LP-01 (dp=0, dn=1, tx_lp_en=1) for t_lpx cycles, then LP-00 with tx_lp_en=1 for t_prep cycles, then HS-0 (tx_hs_en=1, tx_lp_en=0, hs_clk_run=0) for t_zero cycles.
- R3: After HS-0, the lane clocks (tx_hs_en=1, hs_clk_run=1, data_ok=0) for t_pre cycles. It then enters the clocking state with data_ok=1 and stays there while hs_req is high.
- R4: A low hs_req sampled in the clocking state starts exit. The clock keeps running with data_ok=0 for t_post cycles, then HS-0 lasts t_trail cycles, then the lane returns to stop.
- R5: Any timing field equal to 0 gives a phase of exactly one cycle.
- R6: When ovr_hs_sel is 1, tx_hs_en equals ovr_hs_val in the same cycle. When ovr_lp_sel is 1, tx_lp_en equals ovr_lp_val in the same cycle. Neither override changes the sequence.
- R7: A high pwr_dn sampled at an edge puts the lane in power-down from that edge, for as long as pwr_dn stays high. In power-down both enables are 0 whatever the overrides, the LP levels are 0/0 and status bit 2 is 0. One cycle after pwr_dn is released the lane is in stop. pwr_dn takes priority over soft_rst.
- R8: A high soft_rst sampled at an edge, with pwr_dn low, puts the lane in stop at that edge, with tx_hs_en low when no override is selected.
- R9: The status word lane_stat is {mbias_rdy, in_stop, 0, hs_active}. Bit 3 follows the mbias_rdy input. Bit 1 is always 0. hs_active is 1 from the start of HS-0 on entry to the end of trail on exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous return to stop |
| pwr_dn | input | 1 | Clock lane and PHY power-down |
| hs_req | input | 1 | Request high-speed clocking |
| mbias_rdy | input | 1 | Analog bias ready flag, reported in status |
| t_lpx | input | 8 | LP-01 phase length |
| t_prep | input | 8 | LP-00 prepare phase length |
| t_zero | input | 8 | HS-0 phase length on entry |
| t_pre | input | 8 | Clocking time before data lanes may start |
| t_post | input | 8 | Clocking time kept after the request drops |
| t_trail | input | 8 | HS-0 phase length on exit |
| ovr_hs_sel | input | 1 | Take tx_hs_en from ovr_hs_val |
| ovr_hs_val | input | 1 | Override value for tx_hs_en |
| ovr_lp_sel | input | 1 | Take tx_lp_en from ovr_lp_val |
| ovr_lp_val | input | 1 | Override value for tx_lp_en |
| tx_hs_en | output | 1 | High-speed driver enable |
| tx_lp_en | output | 1 | Low-power driver enable |
| lp_dp | output | 1 | LP level for the positive line |
| lp_dn | output | 1 | LP level for the negative line |
| hs_clk_run | output | 1 | HS clock toggling (0 means HS-0 when tx_hs_en is 1) |
| data_ok | output | 1 | Clock-pre has elapsed; data lanes may start |
| lane_stat | output | 4 | {mbias_rdy, in_stop, ulps (0), hs_active} |

## Verification
The state register changes on the first edge that samples hs_req, pwr_dn or soft_rst. The line levels, enables and status therefore move one edge after the stimulus, and the bench samples two nanoseconds after each edge. The override selects act combinationally and are checked in the same cycle, without waiting for an edge. During each entry and exit the bench builds the expected line state for every cycle from the cumulative sums of the programmed counts, with zeros raised to one. Each cycle is compared with that expectation, so a phase that is one cycle short or long shows up at its boundary.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
   typedef enum logic [3:0] {
      DCLK_PDOWN = 4'd0,
      DCLK_STOP  = 4'd1,
      DCLK_LPX   = 4'd2,
      DCLK_PREP  = 4'd3,
      DCLK_ZERO  = 4'd4,
      DCLK_PRE   = 4'd5,
      DCLK_HS    = 4'd6,
      DCLK_POST  = 4'd7,
      DCLK_TRAIL = 4'd8
   } dclk_state_e;

   localparam int DCLK_NUM_EN = 2;   // index 0: HS enable, index 1: LP enable
endpackage

// File: rtl/dclk_phase_timer.sv
module dclk_phase_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/dclk_lane_fsm.sv
module dclk_lane_fsm
   import dclk_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          pwr_dn,
   input  logic          hs_req,
   input  logic          phase_done,
   input  logic [TW-1:0] t_lpx,
   input  logic [TW-1:0] t_prep,
   input  logic [TW-1:0] t_zero,
   input  logic [TW-1:0] t_pre,
   input  logic [TW-1:0] t_post,
   input  logic [TW-1:0] t_trail,
   output logic          ph_load,
   output logic [TW-1:0] ph_val,
   output dclk_state_e   state,
   output logic          fsm_hs_en,
   output logic          fsm_lp_en,
   output logic          lp_dp,
   output logic          lp_dn,
   output logic          clk_run,
   output logic          data_ok
);
   dclk_state_e st_q, st_d;
   logic [TW-1:0] raw;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         DCLK_PDOWN: st_d = DCLK_STOP;
         DCLK_STOP:  if (hs_req) st_d = DCLK_LPX;
         DCLK_LPX:   if (phase_done) st_d = DCLK_PREP;
         DCLK_PREP:  if (phase_done) st_d = DCLK_ZERO;
         DCLK_ZERO:  if (phase_done) st_d = DCLK_PRE;
         DCLK_PRE:   if (phase_done) st_d = DCLK_HS;
         DCLK_HS:    if (!hs_req) st_d = DCLK_POST;
         DCLK_POST:  if (phase_done) st_d = DCLK_TRAIL;
         DCLK_TRAIL: if (phase_done) st_d = DCLK_STOP;
         default:    st_d = DCLK_STOP;
      endcase
      if (soft_rst) st_d = DCLK_STOP;
      if (pwr_dn)   st_d = DCLK_PDOWN;
   end

   always_comb begin
      unique case (st_d)
         DCLK_LPX:   raw = t_lpx;
         DCLK_PREP:  raw = t_prep;
         DCLK_ZERO:  raw = t_zero;
         DCLK_PRE:   raw = t_pre;
         DCLK_POST:  raw = t_post;
         DCLK_TRAIL: raw = t_trail;
         default:    raw = '0;
      endcase
      ph_val  = (raw == '0) ? '0 : raw - 1'b1;
      ph_load = (st_d != st_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= DCLK_STOP;
      else        st_q <= st_d;
   end

   always_comb begin
      fsm_hs_en = 1'b0;
      fsm_lp_en = 1'b0;
      lp_dp     = 1'b0;
      lp_dn     = 1'b0;
      clk_run   = 1'b0;
      data_ok   = 1'b0;
      unique case (st_q)
         DCLK_STOP:  begin fsm_lp_en = 1'b1; lp_dp = 1'b1; lp_dn = 1'b1; end
         DCLK_LPX:   begin fsm_lp_en = 1'b1; lp_dn = 1'b1; end
         DCLK_PREP:  fsm_lp_en = 1'b1;
         DCLK_ZERO,
         DCLK_TRAIL: fsm_hs_en = 1'b1;
         DCLK_PRE,
         DCLK_POST:  begin fsm_hs_en = 1'b1; clk_run = 1'b1; end
         DCLK_HS:    begin fsm_hs_en = 1'b1; clk_run = 1'b1; data_ok = 1'b1; end
         default:    ;
      endcase
   end

   assign state = st_q;
endmodule

// File: rtl/dclk_en_mux.sv
module dclk_en_mux (
   input  logic park,
   input  logic fsm_val,
   input  logic ovr_sel,
   input  logic ovr_val,
   output logic en_out
);
   always_comb begin
      if (park)         en_out = 1'b0;
      else if (ovr_sel) en_out = ovr_val;
      else              en_out = fsm_val;
   end
endmodule

// File: rtl/dclk_lane_seq.sv
module dclk_lane_seq
   import dclk_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          pwr_dn,
   input  logic          hs_req,
   input  logic          mbias_rdy,
   input  logic [TW-1:0] t_lpx,
   input  logic [TW-1:0] t_prep,
   input  logic [TW-1:0] t_zero,
   input  logic [TW-1:0] t_pre,
   input  logic [TW-1:0] t_post,
   input  logic [TW-1:0] t_trail,
   input  logic          ovr_hs_sel,
   input  logic          ovr_hs_val,
   input  logic          ovr_lp_sel,
   input  logic          ovr_lp_val,
   output logic          tx_hs_en,
   output logic          tx_lp_en,
   output logic          lp_dp,
   output logic          lp_dn,
   output logic          hs_clk_run,
   output logic          data_ok,
   output logic [3:0]    lane_stat
);
   localparam int NEN = DCLK_NUM_EN;

   if (TW < 2 || TW > 16) begin : g_tw_bad
      $error("dclk_lane_seq: TW must lie in 2..16");
   end

   logic          ph_load, ph_done;
   logic [TW-1:0] ph_val;
   dclk_state_e   state;
   logic          fsm_hs, fsm_lp;
   logic [NEN-1:0] fsm_en, sel_v, val_v, en_v;

   dclk_phase_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .done(ph_done)
   );

   dclk_lane_fsm #(.TW(TW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pwr_dn(pwr_dn),
      .hs_req(hs_req), .phase_done(ph_done),
      .t_lpx(t_lpx), .t_prep(t_prep), .t_zero(t_zero), .t_pre(t_pre),
      .t_post(t_post), .t_trail(t_trail),
      .ph_load(ph_load), .ph_val(ph_val), .state(state),
      .fsm_hs_en(fsm_hs), .fsm_lp_en(fsm_lp),
      .lp_dp(lp_dp), .lp_dn(lp_dn), .clk_run(hs_clk_run), .data_ok(data_ok)
   );

   assign fsm_en = {fsm_lp, fsm_hs};
   assign sel_v  = {ovr_lp_sel, ovr_hs_sel};
   assign val_v  = {ovr_lp_val, ovr_hs_val};

   for (genvar g = 0; g < NEN; g++) begin : g_en
      dclk_en_mux u_mux (
         .park(state == DCLK_PDOWN), .fsm_val(fsm_en[g]),
         .ovr_sel(sel_v[g]), .ovr_val(val_v[g]), .en_out(en_v[g])
      );
   end

   assign tx_hs_en  = en_v[0];
   assign tx_lp_en  = en_v[1];
   assign lane_stat = {mbias_rdy, state == DCLK_STOP, 1'b0, fsm_hs};
endmodule

// File: rtl/dclk_lane_seq_chk.sv
module dclk_lane_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       soft_rst,
   input logic       pwr_dn,
   input logic       tx_hs_en,
   input logic       tx_lp_en,
   input logic       lp_dp,
   input logic       lp_dn,
   input logic       hs_clk_run,
   input logic       data_ok,
   input logic [3:0] lane_stat
);
   AST_STOP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      lane_stat[2] |-> (lp_dp && lp_dn && !data_ok && !hs_clk_run)); // R1

   AST_LEAVE_STOP_LP01: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lane_stat[2]) && !$past(pwr_dn)) |-> (!lp_dp && lp_dn)); // R2

   AST_CLOCK_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ok) |-> $past(hs_clk_run)); // R3

   AST_PDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (!tx_hs_en && !tx_lp_en && !lane_stat[2])); // R7

   AST_SOFT_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !pwr_dn) |=> lane_stat[2]); // R8
endmodule

bind dclk_lane_seq dclk_lane_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pwr_dn(pwr_dn),
   .tx_hs_en(tx_hs_en), .tx_lp_en(tx_lp_en), .lp_dp(lp_dp), .lp_dn(lp_dn),
   .hs_clk_run(hs_clk_run), .data_ok(data_ok), .lane_stat(lane_stat)
);

// File: tb/dclk_lane_seq_tb_top.sv
module dclk_lane_seq_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 0, pwr_dn = 0, hs_req = 0, mbias_rdy = 1;
   logic [7:0] t_lpx = 1, t_prep = 1, t_zero = 1, t_pre = 1, t_post = 1, t_trail = 1;
   logic ovr_hs_sel = 0, ovr_hs_val = 0, ovr_lp_sel = 0, ovr_lp_val = 0;
   logic tx_hs_en, tx_lp_en, lp_dp, lp_dn, hs_clk_run, data_ok;
   logic [3:0] lane_stat;

   int total = 0;
   int bad = 0;

   // {lp_en, hs_en, dp, dn, clk_run, data_ok, in_stop}
   localparam logic [6:0] E_STOP  = 7'b1011001;
   localparam logic [6:0] E_LPX   = 7'b1001000;
   localparam logic [6:0] E_PREP  = 7'b1000000;
   localparam logic [6:0] E_HS0   = 7'b0100000;
   localparam logic [6:0] E_CLK   = 7'b0100100;
   localparam logic [6:0] E_HS    = 7'b0100110;
   localparam logic [6:0] E_PDOWN = 7'b0000000;

   // {lpx, prep, zero, pre, post, trail}
   localparam logic [47:0] VEC [6] = '{
      48'h01_01_01_01_01_01,
      48'h02_03_04_05_02_03,
      48'h00_00_00_00_00_00,
      48'h05_01_07_02_03_01,
      48'h01_00_02_00_04_00,
      48'h03_02_00_01_00_02
   };

   always #5 clk = ~clk;

   dclk_lane_seq dut_i (.*);

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(string req, logic [6:0] exp);
      logic [6:0] act;
      act = {tx_lp_en, tx_hs_en, lp_dp, lp_dn, hs_clk_run, data_ok, lane_stat[2]};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   task automatic chk_bit(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   task automatic chk_stat(string req, logic [3:0] exp);
      total++;
      if (lane_stat !== exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, lane_stat, exp);
      end
   endtask

   function automatic int eff(logic [7:0] v);
      return (v == 0) ? 1 : int'(v);
   endfunction

   initial begin
      #1;
      repeat (2) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 reset stop", E_STOP);
      chk_stat("R9 status in stop", 4'b1100);

      // table walk: entry (R2, R3), exit (R4), zero counts (R5)
      for (int v = 0; v < 6; v++) begin
         int l, p, z, c, po, tr;
         string tg_in, tg_out;
         {t_lpx, t_prep, t_zero, t_pre, t_post, t_trail} = VEC[v];
         l = eff(t_lpx); p = eff(t_prep); z = eff(t_zero);
         c = eff(t_pre); po = eff(t_post); tr = eff(t_trail);
         tg_in  = (v == 2) ? "R5 entry" : "R2/R3 entry";
         tg_out = (v == 2) ? "R5 exit"  : "R4 exit";
         hs_req = 1'b1;
         for (int i = 1; i <= l + p + z + c + 2; i++) begin
            tick();
            if (i <= l)                 chk(tg_in, E_LPX);
            else if (i <= l + p)        chk(tg_in, E_PREP);
            else if (i <= l + p + z)    chk(tg_in, E_HS0);
            else if (i <= l + p + z + c) chk(tg_in, E_CLK);
            else                        chk(tg_in, E_HS);
         end
         hs_req = 1'b0;
         for (int j = 1; j <= po + tr + 1; j++) begin
            tick();
            if (j <= po)           chk(tg_out, E_CLK);
            else if (j <= po + tr) chk(tg_out, E_HS0);
            else                   chk(tg_out, E_STOP);
         end
      end

      // R6: register overrides act in the same cycle
      ovr_hs_sel = 1; ovr_hs_val = 1;
      #1 chk_bit("R6 hs override", tx_hs_en, 1'b1);
      ovr_lp_sel = 1; ovr_lp_val = 0;
      #1 chk_bit("R6 lp override", tx_lp_en, 1'b0);
      ovr_hs_sel = 0; ovr_lp_sel = 0;
      #1 chk("R6 overrides released", E_STOP);

      // R9 status while clocking, with bias not ready
      {t_lpx, t_prep, t_zero, t_pre, t_post, t_trail} = VEC[0];
      mbias_rdy = 0;
      #1 chk_stat("R9 bias flag follows input", 4'b0100);
      hs_req = 1;
      repeat (5) tick();
      chk("R3 clocking reached", E_HS);
      chk_stat("R9 status while clocking", 4'b0001);
      mbias_rdy = 1;

      // R7: power-down overrides overrides and soft reset
      ovr_hs_sel = 1; ovr_hs_val = 1; ovr_lp_sel = 1; ovr_lp_val = 1;
      pwr_dn = 1; soft_rst = 1;
      tick();
      chk("R7 power-down entered", E_PDOWN);
      soft_rst = 0;
      repeat (3) tick();
      chk("R7 power-down held", E_PDOWN);
      chk_bit("R7 stat stop bit low", lane_stat[2], 1'b0);
      pwr_dn = 0; hs_req = 0; ovr_hs_sel = 0; ovr_lp_sel = 0;
      tick();
      chk("R7 release to stop", E_STOP);

      // R8: soft reset from clocking
      hs_req = 1;
      repeat (5) tick();
      chk("R8 setup clocking", E_HS);
      soft_rst = 1;
      tick();
      chk("R8 soft reset to stop", E_STOP);
      soft_rst = 0; hs_req = 0;
      tick();
      chk("R8 stays stopped", E_STOP);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule